// File: doc/BRIEF.md
# RAM Word to UART Byte Serializer

This block sits between a memory-side source of address/data pairs and the transmit FIFO of a UART. When the source flags that a 16-bit address and a 32-bit data word are stable, and the bus sequencer permits a transmit burst, the block captures both and returns a one-cycle acquired strobe. It then presents the captured frame one byte at a time, most significant byte first. Each byte is offered only while the UART reports room in its transmit FIFO, and it is retired when the UART's select strobe shows it was consumed.

A mode input chooses the frame shape at capture time. Either the two address bytes go out ahead of the four data bytes, giving six bytes, or only the four data bytes go out. A busy output tells the sequencer that a frame is in flight, and no new word is captured until the last byte of the current frame has been consumed.

Top module: `txw_serializer`

## Requirements
- R1: After reset the busy flag `frm_busy_o`, the acquired strobe `word_taken_o` and the byte-ready flag `byte_rdy_o` are all low.
- R2: While idle, a word is captured at the first clock edge where both `word_vld_i` and `burst_en_i` are high. In the following cycle `word_taken_o` is high for exactly one cycle, and `frm_busy_o` is high.
- R3: With `with_addr_i` = 1 at capture, exactly six bytes are sent in this order: address[15:8], address[7:0], data[31:24], data[23:16], data[15:8], data[7:0].
- R4: With `with_addr_i` = 0 at capture, exactly four bytes are sent in this order: data[31:24], data[23:16], data[15:8], data[7:0].
- R5: `byte_rdy_o` is high only while a frame is in flight, `burst_en_i` is high and `uart_full_n_i`... more precisely the active-low room flag `uart_room_n_i` is low. `byte_o` holds its value while no byte is retired.
- R6: A retire strobe `byte_take_i` given while `byte_rdy_o` is low does not advance the frame.
- R7: During a frame, changes on `word_vld_i` and `with_addr_i` have no effect. A word held valid across the last retire is captured at the edge that follows it, and `word_taken_o` rises one cycle later.
- R8: `frm_busy_o` falls in the cycle after the last byte of a frame is retired.
- R9: While idle with `burst_en_i` low, a valid word is not captured and `word_taken_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| with_addr_i | input | 1 | 1: send address bytes before data; 0: data only |
| word_addr_i | input | 16 | Address to send |
| word_data_i | input | 32 | Data word to send |
| word_vld_i | input | 1 | Memory side: address and data stable |
| word_taken_o | output | 1 | One-cycle pulse: word captured |
| burst_en_i | input | 1 | Sequencer permits transmit burst |
| uart_room_n_i | input | 1 | Active-low: UART transmit FIFO has room |
| byte_take_i | input | 1 | UART select strobe: offered byte consumed |
| byte_o | output | 8 | Byte offered to the UART |
| byte_rdy_o | output | 1 | `byte_o` is valid and may be consumed |
| frm_busy_o | output | 1 | A frame is in flight |

## Verification
Two functions can meet in one cycle. One is retiring the last byte of a frame. The other is the memory side holding a fresh word valid, which must not be captured until the frame has ended. The bench keeps `word_vld_i` high, with a flipped mode, through a whole frame including its last retire. It then judges that the frame length still follows the mode captured at the start, that no acquired pulse appears early, and that the waiting word is captured exactly one edge after the last retire. Stalled cycles, in which the FIFO is full or the burst is disabled, are interleaved with spurious retire strobes in order to catch a frame that advances when it should not.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } txw_state_t;
endpackage

// File: rtl/txw_frame_reg.sv
module txw_frame_reg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic                     shift_i,
  input  logic                     mode_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [BYTE_W-1:0]        byte_o,
  output logic                     last_o
);
  localparam int FRAME_W   = ADDR_W + DATA_W;
  localparam int FULL_CNT  = FRAME_W / BYTE_W;
  localparam int DATA_CNT  = DATA_W / BYTE_W;
  localparam int CNT_W     = $clog2(FULL_CNT + 1);

  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic               en;

  assign en = load_i | shift_i;

  always_comb begin
    shreg_d = shreg_q;
    left_d  = left_q;
    if (load_i) begin
      if (mode_i) begin
        shreg_d = {addr_i, data_i};
        left_d  = CNT_W'(FULL_CNT);
      end else begin
        shreg_d = {data_i, {ADDR_W{1'b0}}};
        left_d  = CNT_W'(DATA_CNT);
      end
    end else if (shift_i) begin
      shreg_d = {shreg_q[FRAME_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
      left_d  = left_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      left_q  <= '0;
    end else if (en) begin
      shreg_q <= shreg_d;
      left_q  <= left_d;
    end
  end

  assign byte_o = shreg_q[FRAME_W-1 -: BYTE_W];
  assign last_o = (left_q == CNT_W'(1));
endmodule

// File: rtl/txw_ctrl.sv
module txw_ctrl
  import txw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic word_vld_i,
  input  logic burst_en_i,
  input  logic uart_room_n_i,
  input  logic byte_take_i,
  input  logic last_i,
  output logic load_o,
  output logic shift_o,
  output logic taken_o,
  output logic busy_o,
  output logic rdy_o
);
  txw_state_t state_q, state_d;
  logic       taken_q, taken_d;

  always_comb begin
    state_d = state_q;
    taken_d = 1'b0;
    load_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (word_vld_i && burst_en_i) begin
          state_d = ST_SEND;
          taken_d = 1'b1;
          load_o  = 1'b1;
        end
      end
      ST_SEND: begin
        if (shift_o && last_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy_o  = (state_q == ST_SEND);
  assign rdy_o   = busy_o && burst_en_i && !uart_room_n_i;
  assign shift_o = rdy_o && byte_take_i;
  assign taken_o = taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      taken_q <= 1'b0;
    end else begin
      state_q <= state_d;
      taken_q <= taken_d;
    end
  end
endmodule

// File: rtl/txw_serializer.sv
module txw_serializer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              with_addr_i,
  input  logic [ADDR_W-1:0] word_addr_i,
  input  logic [DATA_W-1:0] word_data_i,
  input  logic              word_vld_i,
  output logic              word_taken_o,
  input  logic              burst_en_i,
  input  logic              uart_room_n_i,
  input  logic              byte_take_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_rdy_o,
  output logic              frm_busy_o
);
  logic load, shift, last;

  txw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_vld_i    (word_vld_i),
    .burst_en_i    (burst_en_i),
    .uart_room_n_i (uart_room_n_i),
    .byte_take_i   (byte_take_i),
    .last_i        (last),
    .load_o        (load),
    .shift_o       (shift),
    .taken_o       (word_taken_o),
    .busy_o        (frm_busy_o),
    .rdy_o         (byte_rdy_o)
  );

  txw_frame_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .shift_i (shift),
    .mode_i  (with_addr_i),
    .addr_i  (word_addr_i),
    .data_i  (word_data_i),
    .byte_o  (byte_o),
    .last_o  (last)
  );
endmodule

// File: rtl/txw_serializer_chk.sv
module txw_serializer_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_taken_o,
  input logic              burst_en_i,
  input logic              uart_room_n_i,
  input logic              byte_take_i,
  input logic [BYTE_W-1:0] byte_o,
  input logic              byte_rdy_o,
  input logic              frm_busy_o
);
  localparam int FULL_CNT = (ADDR_W + DATA_W) / BYTE_W;
  localparam int DATA_CNT = DATA_W / BYTE_W;
  localparam int CNT_W    = $clog2(FULL_CNT + 2);

  logic             fire;
  logic [CNT_W-1:0] takes_q;

  assign fire = byte_rdy_o && byte_take_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) takes_q <= '0;
    else if (word_taken_o) takes_q <= fire ? CNT_W'(1) : CNT_W'(0);
    else if (fire) takes_q <= takes_q + CNT_W'(1);
  end

  p_taken_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_taken_o |=> !word_taken_o);
  p_taken_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_taken_o |-> frm_busy_o);
  p_rdy_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rdy_o |-> (frm_busy_o && burst_en_i && !uart_room_n_i));
  p_byte_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_busy_o && !fire) |=> $stable(byte_o));
  p_no_early_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_busy_o && !fire) |=> !word_taken_o);
  p_frame_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frm_busy_o) |-> (takes_q == CNT_W'(FULL_CNT) || takes_q == CNT_W'(DATA_CNT)));
endmodule

bind txw_serializer txw_serializer_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BYTE_W (BYTE_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .word_taken_o  (word_taken_o),
  .burst_en_i    (burst_en_i),
  .uart_room_n_i (uart_room_n_i),
  .byte_take_i   (byte_take_i),
  .byte_o        (byte_o),
  .byte_rdy_o    (byte_rdy_o),
  .frm_busy_o    (frm_busy_o)
);

// File: tb/txw_serializer_tb_top.sv
`timescale 1ns/1ps
module txw_serializer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        with_addr_i;
  logic [15:0] word_addr_i;
  logic [31:0] word_data_i;
  logic        word_vld_i;
  logic        word_taken_o;
  logic        burst_en_i;
  logic        uart_room_n_i;
  logic        byte_take_i;
  logic [7:0]  byte_o;
  logic        byte_rdy_o;
  logic        frm_busy_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  txw_serializer dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .with_addr_i   (with_addr_i),
    .word_addr_i   (word_addr_i),
    .word_data_i   (word_data_i),
    .word_vld_i    (word_vld_i),
    .word_taken_o  (word_taken_o),
    .burst_en_i    (burst_en_i),
    .uart_room_n_i (uart_room_n_i),
    .byte_take_i   (byte_take_i),
    .byte_o        (byte_o),
    .byte_rdy_o    (byte_rdy_o),
    .frm_busy_o    (frm_busy_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input bit mode, input logic [15:0] a,
                                          input logic [31:0] d, input int i);
    logic [47:0] fr;
    fr = {a, d};
    if (mode) return 8'(fr >> (8 * (5 - i)));
    else      return 8'(d >> (8 * (3 - i)));
  endfunction

  // retire every byte of a captured frame; stall / noise as requested
  task automatic drain(input bit mode, input logic [15:0] a, input logic [31:0] d,
                       input bit stall, input bit noise);
    int n;
    n = mode ? 6 : 4;
    for (int i = 0; i < n; i++) begin
      if (stall) begin
        uart_room_n_i = 1'b1; byte_take_i = 1'b1;
        #1 chk(byte_rdy_o == 1'b0, "R5 rdy with fifo full", byte_rdy_o, 0);
        burst_en_i = 1'b0; uart_room_n_i = 1'b0;
        #1 chk(byte_rdy_o == 1'b0, "R5 rdy with burst off", byte_rdy_o, 0);
        @(posedge clk); @(negedge clk);
        chk(byte_o == exp_byte(mode, a, d, i), "R6 take ignored", byte_o, exp_byte(mode, a, d, i));
        chk(frm_busy_o == 1'b1, "R6 busy kept", frm_busy_o, 1);
        burst_en_i = 1'b1;
      end
      uart_room_n_i = 1'b0; byte_take_i = 1'b1;
      if (noise && i == n - 1) with_addr_i = mode;
      #1;
      chk(byte_rdy_o == 1'b1, "R5 rdy", byte_rdy_o, 1);
      chk(byte_o == exp_byte(mode, a, d, i), mode ? "R3 byte order" : "R4 byte order",
          byte_o, exp_byte(mode, a, d, i));
      @(posedge clk); @(negedge clk);
      byte_take_i = 1'b0;
      if (i < n - 1) chk(word_taken_o == 1'b0, "R7 no capture mid-frame", word_taken_o, 0);
      if (noise && i < n - 1) with_addr_i = ~with_addr_i;
    end
    chk(frm_busy_o == 1'b0, "R8 busy falls", frm_busy_o, 0);
    chk(word_taken_o == 1'b0, "R7 no early capture", word_taken_o, 0);
  endtask

  task automatic send_frame(input bit mode, input logic [15:0] a, input logic [31:0] d,
                            input bit stall, input bit noise);
    @(negedge clk);
    with_addr_i = mode; word_addr_i = a; word_data_i = d;
    word_vld_i = 1'b1; burst_en_i = 1'b1; byte_take_i = 1'b0; uart_room_n_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(word_taken_o == 1'b1, "R2 taken pulse", word_taken_o, 1);
    chk(frm_busy_o == 1'b1, "R2 busy", frm_busy_o, 1);
    word_vld_i = noise;
    if (noise) with_addr_i = ~mode;
    drain(mode, a, d, stall, noise);
    if (noise) begin
      // word held valid across last retire: captured at the next edge
      @(posedge clk); @(negedge clk);
      chk(word_taken_o == 1'b1, "R7 capture after frame", word_taken_o, 1);
      word_vld_i = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(word_taken_o == 1'b0, "R2 single pulse", word_taken_o, 0);
      drain(mode, a, d, 1'b0, 1'b0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    with_addr_i = 1'b0; word_addr_i = '0; word_data_i = '0;
    word_vld_i = 1'b0; burst_en_i = 1'b0; uart_room_n_i = 1'b0; byte_take_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(frm_busy_o == 1'b0, "R1 busy", frm_busy_o, 0);
    chk(word_taken_o == 1'b0, "R1 taken", word_taken_o, 0);
    chk(byte_rdy_o == 1'b0, "R1 rdy", byte_rdy_o, 0);
    rst_n = 1'b1;

    // R9: burst disabled blocks capture
    word_vld_i = 1'b1; burst_en_i = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); @(negedge clk);
      chk(word_taken_o == 1'b0 && frm_busy_o == 1'b0, "R9 no capture", word_taken_o, 0);
    end
    word_vld_i = 1'b0;

    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 8; k++) begin
        send_frame(m[0], 16'h1357 + 16'(k) * 16'h2461,
                   32'h89AB_CDEF ^ (32'(k) * 32'h0102_0408),
                   k[0], (k == 3) || (k == 6));
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule